// File: doc/BRIEF.md
# Run-Time Configurable Viterbi Path Metric Unit

This block performs the branch-metric and add-compare-select work of a hard-decision Viterbi decoder. The constraint length K (5 to 9) and the number of coded bits per symbol n (2, 3 or 4, for rates 1/2, 1/3 and 1/4) are set at run time. Up to four K-bit generator polynomials are also supplied at run time. For each received symbol of n hard bits, the unit updates all 2^(K-1) path metrics. It emits one survivor decision bit per state. The result goes to a separate traceback stage.

The trellis is walked one butterfly per clock. Butterfly j reads the two predecessor states 2j and 2j+1. It produces the two successor states j (input bit 0) and j + 2^(K-2) (input bit 1). Path metrics are 10 bits wide. They are held in two internal register banks that swap roles on every trellis step. They are normalised when they grow past half range. A symbol is taken only while the unit is idle. A step lasts 2^(K-2) busy cycles, and `step_done` marks its last butterfly.

Top module: `vit_pmu`

## Requirements
- R1: For a symbol accepted with `cfg_k`=K, the unit emits exactly 2^(K-2) results. One result appears per cycle, on consecutive cycles starting one cycle after acceptance. `dec_bfly` counts up from 0. `step_done` is high together with the last result and at no other time.
- R2: The expected bit i of a transition from state p on input u is the XOR over b<K of poly_i[b] AND e[b]. Here e = p + u·2^(K-1), and poly_i is `cfg_poly[i*9 +: 9]`. Polynomial bits at positions K and above have no effect. The branch metric is the number of positions i<n where `sym_bits[i]` differs from that expected bit.
- R3: For each successor, the two candidates are (normalised old metric of predecessor 2j or 2j+1) plus its branch metric. The smaller candidate is kept, and on a tie predecessor 2j wins. The decision bit is 1 exactly when predecessor 2j+1 wins. `dec_bits[0]`/`dec_pm_lo` belong to state j, and `dec_bits[1]`/`dec_pm_hi` belong to state j+2^(K-2).
- R4: Metric arithmetic saturates at 1023. A stored metric of 1023 is treated as unreachable: adding a branch metric to it, or normalising it, leaves 1023.
- R5: After reset, or after an `init` pulse while idle, state 0 holds metric 0 and every other state holds 1023.
- R6: Normalisation works across steps. If any metric written in a step is 512 or more, then at the start of the next step the smallest metric written in that step is subtracted from every reachable stored metric before the add.
- R7: `busy` rises the cycle after a symbol is accepted. It falls with the step's last result. `sym_valid` has no effect while `busy` is high.
- R8: `sym_bits` at positions n and above do not affect any metric or decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Reload start metrics while idle |
| cfg_k | input | 4 | Constraint length, 5..9 |
| cfg_n | input | 3 | Coded bits per symbol, 2..4 |
| cfg_poly | input | 36 | Four 9-bit generator polynomial fields |
| sym_valid | input | 1 | Received symbol offered |
| sym_bits | input | 4 | Hard received bits, bit i = coded bit i |
| busy | output | 1 | Step in progress |
| dec_valid | output | 1 | Butterfly result valid |
| dec_bfly | output | 7 | Butterfly index j of this result |
| dec_bits | output | 2 | Decisions for states j and j+2^(K-2) |
| dec_pm_lo | output | 10 | New metric of state j |
| dec_pm_hi | output | 10 | New metric of state j+2^(K-2) |
| step_done | output | 1 | Last butterfly of the step |

## Verification
A wrong internal metric does not stay hidden. Each metric feeds two successors in the very next step. Those successors' `dec_pm_lo`/`dec_pm_hi` and decision bits are compared against an independent model on every butterfly. So a corrupted bank entry, a bad branch metric or a wrong tie rule shows at the ports within one trellis step. A normalisation error, such as a wrong subtraction amount or the wrong step, shifts every reachable metric by the same amount. That shift appears on the first result of the following step. Long runs of noisy symbols push metrics past half range so that this path is exercised many times.

// File: rtl/vit_pkg.sv
// Shared sizing constants for the Viterbi path metric unit.
// Assumes at most four coded bits per symbol and constraint length up to 9.
package vit_pkg;
    localparam int KMAX = 9;                       // largest constraint length
    localparam int NMAX = 4;                       // largest coded bits per symbol
    localparam int PMW  = 10;                      // path metric width
    localparam int SW   = KMAX - 1;                // state index width
    localparam int BW   = KMAX - 2;                // butterfly index width
    localparam int NS   = 1 << SW;                 // largest state count
    localparam int BMW  = $clog2(NMAX + 1);        // branch metric width
    localparam logic [PMW-1:0] PM_MAX  = {PMW{1'b1}};
    localparam logic [PMW-1:0] PM_HALF = PMW'(1) << (PMW - 1);
endpackage

// File: rtl/vit_bmu.sv
// Hamming branch metric for one trellis transition.
// Builds the encoder register from predecessor state and input bit, forms the
// expected coded bits from the polynomials, and counts mismatches over n bits.
// Assumes state bits above K-2 are zero (state < 2^(K-1)).
module vit_bmu
    import vit_pkg::*;
(
    input  logic [SW-1:0]        state,
    input  logic                 in_bit,
    input  logic [3:0]           k,
    input  logic [2:0]           n,
    input  logic [NMAX*KMAX-1:0] poly,
    input  logic [NMAX-1:0]      sym,
    output logic [BMW-1:0]       bm
);
    logic [KMAX-1:0] enc_reg;

    // Combine input bit and state, then count mismatching coded bits.
    always_comb begin
        enc_reg = KMAX'(state) | (KMAX'(in_bit) << (k - 4'd1));
        bm = '0;
        for (int i = 0; i < NMAX; i++) begin
            if (i < int'(n)) begin
                bm = bm + BMW'((^(enc_reg & poly[i*KMAX +: KMAX])) ^ sym[i]);
            end
        end
    end
endmodule

// File: rtl/vit_acs.sv
// One add-compare-select: two saturating candidates, keep the smaller.
// A tie keeps candidate 0 (the even predecessor). An input of PM_MAX is
// unreachable and stays PM_MAX.
module vit_acs
    import vit_pkg::*;
(
    input  logic [PMW-1:0] pm0,
    input  logic [PMW-1:0] pm1,
    input  logic [BMW-1:0] bm0,
    input  logic [BMW-1:0] bm1,
    output logic [PMW-1:0] pm_new,
    output logic           dec
);
    logic [PMW-1:0] cand0, cand1;

    function automatic logic [PMW-1:0] sat_add(input logic [PMW-1:0] a,
                                               input logic [BMW-1:0] b);
        logic [PMW:0] s;
        s = {1'b0, a} + (PMW+1)'(b);
        if (a == PM_MAX || s > {1'b0, PM_MAX}) return PM_MAX;
        return s[PMW-1:0];
    endfunction

    // Add branch metrics, pick the survivor, record which predecessor won.
    always_comb begin
        cand0  = sat_add(pm0, bm0);
        cand1  = sat_add(pm1, bm1);
        dec    = (cand1 < cand0);
        pm_new = dec ? cand1 : cand0;
    end
endmodule

// File: rtl/vit_pmu.sv
// Run-time configurable Viterbi path metric unit.
// Accepts one hard symbol while idle, then processes one butterfly per cycle
// for 2^(K-2) cycles. It reads old metrics from one bank and writes new ones
// to the other; the banks swap at the end of each step. Assumes cfg_k in 5..9
// and cfg_n in 2..4. cfg_poly must stay stable while busy.
module vit_pmu
    import vit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic [3:0]           cfg_k,
    input  logic [2:0]           cfg_n,
    input  logic [NMAX*KMAX-1:0] cfg_poly,
    input  logic                 sym_valid,
    input  logic [NMAX-1:0]      sym_bits,
    output logic                 busy,
    output logic                 dec_valid,
    output logic [BW-1:0]        dec_bfly,
    output logic [1:0]           dec_bits,
    output logic [PMW-1:0]       dec_pm_lo,
    output logic [PMW-1:0]       dec_pm_hi,
    output logic                 step_done
);
    logic [PMW-1:0]  bank [2][NS];
    logic            cur;
    logic [BW-1:0]   bf;
    logic [3:0]      k_r;
    logic [2:0]      n_r;
    logic [NMAX-1:0] sym_r;
    logic [PMW-1:0]  sub_r, run_min, prev_min;
    logic            run_over, prev_over;

    logic [SW-1:0]   half_st, p0, p1, dest_lo, dest_hi;
    logic [BW-1:0]   last_bf;
    logic [PMW-1:0]  old0, old1, mn;
    logic            ov;
    logic [BMW-1:0]  bm [4];
    logic [PMW-1:0]  pm_new [2];
    logic [1:0]      dec_w;

    // Butterfly addressing and normalised reads of the two predecessors.
    always_comb begin
        half_st = SW'(1) << (k_r - 4'd2);
        last_bf = BW'(half_st - SW'(1));
        p0      = {bf, 1'b0};
        p1      = {bf, 1'b1};
        dest_lo = SW'(bf);
        dest_hi = SW'(bf) | half_st;
        old0    = (bank[cur][p0] == PM_MAX) ? PM_MAX : bank[cur][p0] - sub_r;
        old1    = (bank[cur][p1] == PM_MAX) ? PM_MAX : bank[cur][p1] - sub_r;
    end

    // Four branch metrics: index = 2*input_bit + predecessor_parity.
    for (genvar g = 0; g < 4; g++) begin : g_bmu
        vit_bmu u_bmu (
            .state  (g[0] ? p1 : p0),
            .in_bit (g[1]),
            .k      (k_r),
            .n      (n_r),
            .poly   (cfg_poly),
            .sym    (sym_r),
            .bm     (bm[g])
        );
    end

    // Two ACS units of the butterfly, one per input bit.
    for (genvar u = 0; u < 2; u++) begin : g_acs
        vit_acs u_acs (
            .pm0    (old0),
            .pm1    (old1),
            .bm0    (bm[2*u]),
            .bm1    (bm[2*u+1]),
            .pm_new (pm_new[u]),
            .dec    (dec_w[u])
        );
    end

    // Running minimum and half-range flag including this butterfly.
    always_comb begin
        mn = run_min;
        if (pm_new[0] < mn) mn = pm_new[0];
        if (pm_new[1] < mn) mn = pm_new[1];
        ov = run_over || (pm_new[0] >= PM_HALF) || (pm_new[1] >= PM_HALF);
    end

    // Step control, bank writes and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                bank[0][i] <= (i == 0) ? '0 : PM_MAX;
                bank[1][i] <= (i == 0) ? '0 : PM_MAX;
            end
            cur       <= 1'b0;
            busy      <= 1'b0;
            bf        <= '0;
            k_r       <= 4'd5;
            n_r       <= 3'd2;
            sym_r     <= '0;
            sub_r     <= '0;
            run_min   <= PM_MAX;
            run_over  <= 1'b0;
            prev_min  <= '0;
            prev_over <= 1'b0;
            dec_valid <= 1'b0;
            dec_bfly  <= '0;
            dec_bits  <= '0;
            dec_pm_lo <= '0;
            dec_pm_hi <= '0;
            step_done <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            step_done <= 1'b0;
            if (busy) begin
                bank[~cur][dest_lo] <= pm_new[0];
                bank[~cur][dest_hi] <= pm_new[1];
                dec_valid <= 1'b1;
                dec_bfly  <= bf;
                dec_bits  <= dec_w;
                dec_pm_lo <= pm_new[0];
                dec_pm_hi <= pm_new[1];
                if (bf == last_bf) begin
                    busy      <= 1'b0;
                    step_done <= 1'b1;
                    cur       <= ~cur;
                    prev_min  <= mn;
                    prev_over <= ov;
                end else begin
                    bf       <= bf + BW'(1);
                    run_min  <= mn;
                    run_over <= ov;
                end
            end else if (init) begin
                for (int i = 0; i < NS; i++) begin
                    bank[cur][i] <= (i == 0) ? '0 : PM_MAX;
                end
                prev_min  <= '0;
                prev_over <= 1'b0;
            end else if (sym_valid) begin
                busy     <= 1'b1;
                bf       <= '0;
                k_r      <= cfg_k;
                n_r      <= cfg_n;
                sym_r    <= sym_bits;
                run_min  <= PM_MAX;
                run_over <= 1'b0;
                sub_r    <= prev_over ? prev_min : '0;
            end
        end
    end

    // The last butterfly result carries the step_done marker.
    assert_done_with_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> dec_valid);

    // Results within a step are contiguous and ascending.
    assert_bfly_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !step_done) |=> (dec_valid && dec_bfly == $past(dec_bfly) + BW'(1)));

    // An accepted symbol starts a step on the next cycle.
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !init && sym_valid) |=> busy);

    // The unit is idle right after a step ends.
    assert_idle_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> !busy);

    // Results only appear while a step was running.
    assert_result_in_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(busy));
endmodule

// File: tb/vit_pmu_test.sv
// Scoreboard bench: a driver task models each step and queues expected results;
// a monitor compares every emitted butterfly result against the queue.
module vit_pmu_test;
    import vit_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXV = 1023;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 init = 1'b0;
    logic [3:0]           cfg_k = 4'd5;
    logic [2:0]           cfg_n = 3'd2;
    logic [NMAX*KMAX-1:0] cfg_poly = '0;
    logic                 sym_valid = 1'b0;
    logic [NMAX-1:0]      sym_bits = '0;
    logic                 busy, dec_valid, step_done;
    logic [BW-1:0]        dec_bfly;
    logic [1:0]           dec_bits;
    logic [PMW-1:0]       dec_pm_lo, dec_pm_hi;

    vit_pmu uut (
        .clk(clk), .rst_n(rst_n), .init(init), .cfg_k(cfg_k), .cfg_n(cfg_n),
        .cfg_poly(cfg_poly), .sym_valid(sym_valid), .sym_bits(sym_bits),
        .busy(busy), .dec_valid(dec_valid), .dec_bfly(dec_bfly),
        .dec_bits(dec_bits), .dec_pm_lo(dec_pm_lo), .dec_pm_hi(dec_pm_hi),
        .step_done(step_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [29:0] expq[$];
    int pm[NS];
    bit over_m;
    int pmin_m;
    int norm_count = 0;
    int k_m, n_m;

    function automatic int bm_f(int p, int u, logic [3:0] sym);
        int r = p | (u << (k_m - 1));
        int c = 0;
        for (int i = 0; i < n_m; i++) begin
            int e = 0;
            for (int b = 0; b < k_m; b++)
                if (cfg_poly[i*KMAX + b] && ((r >> b) & 1) == 1) e ^= 1;
            if (e != int'(sym[i])) c++;
        end
        return c;
    endfunction

    function automatic int sat(int a, int b);
        if (a == MAXV) return MAXV;
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    // Monitor: compare each result with the head of the expected queue (R1, R3).
    always @(negedge clk) begin
        if (rst_n && step_done && !dec_valid) begin
            checks++; errors++;
            $display("FAIL R1 step_done without result: actual 1 expected 0");
        end
        if (rst_n && dec_valid) begin
            logic [29:0] act, ex;
            checks++;
            act = {step_done, dec_bfly, dec_bits, dec_pm_lo, dec_pm_hi};
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result: actual %h expected none", act);
            end else begin
                ex = expq.pop_front();
                if (act !== ex) begin
                    errors++;
                    $display("FAIL R3 result {done,bfly,dec,lo,hi}: actual %h expected %h", act, ex);
                end
            end
        end
    end

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        for (int s = 0; s < NS; s++) pm[s] = (s == 0) ? 0 : MAXV;   // R5
        over_m = 0;
        pmin_m = 0;
    endtask

    // Driver: model one step (R2-R6), queue expectations, offer the symbol.
    task automatic run_step(logic [3:0] sym, bit junk);
        int sub, half, mn;
        bit ov;
        int o[NS];
        int nw[NS];
        sub = over_m ? pmin_m : 0;
        if (sub != 0) norm_count++;
        half = 1 << (k_m - 2);
        mn = MAXV;
        ov = 0;
        for (int s = 0; s < 2*half; s++) o[s] = (pm[s] == MAXV) ? MAXV : pm[s] - sub;
        for (int j = 0; j < half; j++) begin
            int v[2];
            bit d[2];
            for (int u = 0; u < 2; u++) begin
                int c0 = sat(o[2*j], bm_f(2*j, u, sym));
                int c1 = sat(o[2*j+1], bm_f(2*j+1, u, sym));
                d[u] = (c1 < c0);
                v[u] = d[u] ? c1 : c0;
                nw[j + u*half] = v[u];
                if (v[u] < mn) mn = v[u];
                if (v[u] >= 512) ov = 1;
            end
            expq.push_back({(j == half-1), 7'(j), d[1], d[0], 10'(v[0]), 10'(v[1])});
        end
        for (int s = 0; s < 2*half; s++) pm[s] = nw[s];
        pmin_m = mn;
        over_m = ov;
        @(negedge clk);
        sym_valid = 1'b1;
        sym_bits = sym;
        @(negedge clk);
        checks++;
        if (busy !== 1'b1) begin
            errors++;
            $display("FAIL R7 busy after accept: actual %b expected 1", busy);
        end
        // R7: offers while busy must be ignored.
        sym_valid = junk;
        sym_bits = ~sym;
        @(negedge clk);
        sym_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic configure(int k, int n, logic [NMAX*KMAX-1:0] poly);
        cfg_k = 4'(k);
        cfg_n = 3'(n);
        cfg_poly = poly;
        k_m = k;
        n_m = n;
        do_init();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || dec_valid !== 1'b0 || step_done !== 1'b0) begin
            errors++;
            $display("FAIL R5 reset outputs: actual %b%b%b expected 000", busy, dec_valid, step_done);
        end
        // R5: first step straight after reset uses the reset start metrics.
        k_m = 5; n_m = 2;
        cfg_poly = {18'd0, 9'h01D, 9'h013};
        for (int s = 0; s < NS; s++) pm[s] = (s == 0) ? 0 : MAXV;
        over_m = 0; pmin_m = 0;
        run_step(4'b0011, 1'b0);
        // R2, R8: K=5 rate 1/2, random upper symbol bits must not matter.
        configure(5, 2, {18'h3FFFF, 9'h01D, 9'h013});
        for (int i = 0; i < 20; i++) run_step(4'($urandom), (i % 3) == 0);
        // R2: K=7 rate 1/3 with junk polynomial bits above K.
        configure(7, 3, {9'h1FF, 9'h1F5, 9'h179, 9'h15B});
        for (int i = 0; i < 10; i++) run_step(4'($urandom), 1'b1);
        // R1: K=9 rate 1/4, 128 butterflies per step.
        configure(9, 4, {9'h1ED, 9'h19B, 9'h16F, 9'h1D3});
        for (int i = 0; i < 6; i++) run_step(4'($urandom), 1'b0);
        // R3: all-zero symbols give many equal candidates (tie rule).
        configure(6, 2, {18'd0, 9'h02D, 9'h02D});
        for (int i = 0; i < 8; i++) run_step(4'b0000, 1'b0);
        // R4, R6: long noisy run so metrics pass half range and get normalised.
        configure(5, 4, {9'h01B, 9'h015, 9'h01D, 9'h013});
        for (int i = 0; i < 6000; i++) run_step(4'($urandom), 1'b0);
        checks++;
        if (norm_count == 0) begin
            errors++;
            $display("FAIL R6 normalisation steps: actual 0 expected >0");
        end
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: actual %0d left expected 0", expq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule